// File: doc/BRIEF.md
# Paged Internal Data Memory Unit

This unit holds the internal data space of an 8051-style core. It takes one access request per cycle and returns its read data one cycle later. Each request is a byte access, a working-register access or a single-bit access. Byte accesses to the lower half of the 8-bit address space always reach RAM. In the upper half, the access mode decides the target: indirect requests reach the top 128 RAM bytes, and direct requests go to a paged special-function-register (SFR) space.

The SFR contents are kept outside the unit. The unit drives a strobe, the current page number, the address and the write data to an external SFR file. That file returns read data in the same cycle. The page number itself is held in a register inside the unit at one direct address.

Working-register requests name register n (0..7) of the bank picked by the bank-select input. Bit requests address the bit-addressable bytes. A bit write is a read-modify-write completed in a single cycle.

The request side uses valid/ready. `req_ready` is always high, because every request completes in its accept cycle. The response side has no back-pressure: `rsp_valid` pulses for one cycle, exactly one cycle after each accepted request, and the consumer must take the data then.

Top module: `idata_unit`

## Requirements
- R1: The unit stores 256 bytes. An indirect byte write to any address 0x00–0xFF is returned by a later indirect byte read of that address.
- R2: For addresses 0x00–0x7F, direct and indirect byte accesses reach the same RAM byte.
- R3: For addresses 0x80–0xFF, an indirect byte access reaches RAM. A direct byte access does not read or write RAM: a later indirect read of that address returns the earlier RAM value.
- R4: A register request (`req_kind` = 2'b01) addresses RAM byte {3'b000, `bank_sel`, `req_addr[2:0]`}. `req_indirect` has no effect on it.
- R5: A bit request (`req_kind` = 2'b10) with bit address below 0x80 targets byte 0x20 + `req_addr[6:3]`, bit `req_addr[2:0]`. A bit write changes only that bit to `req_bit`. A bit read returns {7'b0, bit}.
- R6: A bit request with bit address 0x80–0xFF writes nothing to RAM and returns 0x00.
- R7: The page register sits at direct address 0x84 and resets to 0x00. A direct write there sets it, and a direct read returns it. Accesses to it do not raise `sfr_sel`.
- R8: A direct byte access to any other address 0x80–0xFF raises `sfr_sel` in its accept cycle. In that cycle, `sfr_page` is the page register, `sfr_addr` is the address, and `sfr_we` and `sfr_wdata` follow the request. The `sfr_rdata` seen in that cycle is returned as the response.
- R9: `rsp_valid` is high exactly one cycle after each accepted request. For a write, the response carries the contents before the write (the old value for a bit write, in bit form). `req_ready` is always 1.
- R10: After reset, `rsp_valid` and `sfr_sel` are low.
- Byte requests use `req_kind` 2'b00, and 2'b11 is treated as a byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_kind | input | 2 | 00 byte, 01 register, 10 bit, 11 byte |
| req_indirect | input | 1 | 1 = indirect byte access |
| req_we | input | 1 | Write request |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Byte write data |
| req_bit | input | 1 | Bit write value |
| bank_sel | input | 2 | Register bank select |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 8 | Response data |
| sfr_sel | output | 1 | SFR access strobe |
| sfr_we | output | 1 | SFR write |
| sfr_page | output | 8 | Current SFR page |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, same cycle |

## Verification
The hardest case to reach is the dual mapping of the upper half. A direct write there must leave the RAM byte at the same address untouched, and this can only be seen through a later indirect read. The stimulus first fills the RAM through indirect writes. It then issues direct writes and reads to the same upper addresses, and reads the bytes back indirectly to confirm they are unchanged. Page changes sit between SFR accesses, so that `sfr_page` is seen to follow the page register. Out-of-range bit writes are checked the same way, against bytes that have known contents.

// File: rtl/idata_pkg.sv
`timescale 1ns/1ps
package idata_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;

  typedef enum logic [1:0] {
    K_BYTE = 2'b00,
    K_REG  = 2'b01,
    K_BIT  = 2'b10,
    K_RSVD = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RAM_BYTE,
    SRC_RAM_BIT,
    SRC_SFR,
    SRC_PAGE
  } src_e;

  typedef struct packed {
    src_e          src;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic          bit_mode;
    logic [2:0]    bit_pos;
    logic          sfr_sel;
    logic          page_we;
  } route_t;
endpackage

// File: rtl/idata_decode.sv
`timescale 1ns/1ps
module idata_decode
  import idata_pkg::*;
#(
  parameter logic [AW-1:0] PAGE_ADDR = 8'h84,
  parameter logic [AW-1:0] BIT_BASE  = 8'h20,
  parameter int unsigned   BANK_W    = 2
) (
  input  logic              valid,
  input  logic [1:0]        kind,
  input  logic              indirect,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [BANK_W-1:0] bank,
  output route_t            route
);
  localparam int unsigned REG_W = 3;
  localparam int unsigned PAD_W = AW - BANK_W - REG_W;

  always_comb begin
    route          = '0;
    route.src      = SRC_NONE;
    if (valid) begin
      unique case (kind_e'(kind))
        K_REG: begin
          route.src      = SRC_RAM_BYTE;
          route.ram_addr = {{PAD_W{1'b0}}, bank, addr[REG_W-1:0]};
          route.ram_we   = we;
        end
        K_BIT: begin
          if (!addr[AW-1]) begin
            route.src      = SRC_RAM_BIT;
            route.ram_addr = BIT_BASE + {4'b0000, addr[6:3]};
            route.bit_mode = 1'b1;
            route.bit_pos  = addr[2:0];
            route.ram_we   = we;
          end
        end
        default: begin
          if (addr[AW-1] && !indirect) begin
            if (addr == PAGE_ADDR) begin
              route.src     = SRC_PAGE;
              route.page_we = we;
            end else begin
              route.src     = SRC_SFR;
              route.sfr_sel = 1'b1;
            end
          end else begin
            route.src      = SRC_RAM_BYTE;
            route.ram_addr = addr;
            route.ram_we   = we;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/idata_ram.sv
`timescale 1ns/1ps
module idata_ram
  import idata_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          bit_mode,
  input  logic [2:0]    bit_pos,
  input  logic          bit_val,
  input  logic [DW-1:0] wbyte,
  output logic [DW-1:0] rdata
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur;
  logic [DW-1:0] merged;
  logic [IW-1:0] idx;

  assign idx = addr[IW-1:0];
  assign cur = mem[idx];

  for (genvar g = 0; g < DW; g++) begin : g_merge
    always_comb begin
      if (!bit_mode)                   merged[g] = wbyte[g];
      else if (bit_pos == 3'(g))       merged[g] = bit_val;
      else                             merged[g] = cur[g];
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= cur;
  end

  // R5
  bit_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bit_mode) |-> ($countones(merged ^ cur) <= 1));

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(merged)));
endmodule

// File: rtl/idata_sfr_port.sv
`timescale 1ns/1ps
module idata_sfr_port
  import idata_pkg::*;
#(
  parameter logic [AW-1:0] PAGE_ADDR = 8'h84
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          page_we_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sfr_rdata,
  output logic          sfr_sel,
  output logic          sfr_we,
  output logic [DW-1:0] sfr_page,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] cap_q,
  output logic [DW-1:0] page_rd_q
);
  logic [DW-1:0] page_q;

  assign sfr_sel   = sel_i;
  assign sfr_we    = sel_i & we_i;
  assign sfr_page  = page_q;
  assign sfr_addr  = addr_i;
  assign sfr_wdata = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q    <= '0;
      cap_q     <= '0;
      page_rd_q <= '0;
    end else begin
      if (page_we_i) page_q <= wdata_i;
      if (sel_i)     cap_q  <= sfr_rdata;
      page_rd_q <= page_q;
    end
  end

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we_i |=> $stable(page_q));

  // R8
  strobe_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i |-> (addr_i[AW-1] && addr_i != PAGE_ADDR && !page_we_i));
endmodule

// File: rtl/idata_unit.sv
`timescale 1ns/1ps
module idata_unit
  import idata_pkg::*;
#(
  parameter logic [7:0] PAGE_ADDR = 8'h84,
  parameter logic [7:0] BIT_BASE  = 8'h20,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned DEPTH    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_indirect,
  input  logic              req_we,
  input  logic [7:0]        req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              req_bit,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              sfr_sel,
  output logic              sfr_we,
  output logic [7:0]        sfr_page,
  output logic [7:0]        sfr_addr,
  output logic [7:0]        sfr_wdata,
  input  logic [7:0]        sfr_rdata
);
  route_t        route;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] cap_q;
  logic [DW-1:0] page_rd_q;
  src_e          src_q;
  logic [2:0]    bitpos_q;

  assign req_ready = 1'b1;

  idata_decode #(.PAGE_ADDR(PAGE_ADDR), .BIT_BASE(BIT_BASE), .BANK_W(BANK_W)) u_dec (
    .valid(req_valid), .kind(req_kind), .indirect(req_indirect), .we(req_we),
    .addr(req_addr), .bank(bank_sel), .route(route)
  );

  idata_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(route.ram_we), .addr(route.ram_addr),
    .bit_mode(route.bit_mode), .bit_pos(route.bit_pos), .bit_val(req_bit),
    .wbyte(req_wdata), .rdata(ram_rdata)
  );

  idata_sfr_port #(.PAGE_ADDR(PAGE_ADDR)) u_sfr (
    .clk(clk), .rst_n(rst_n), .sel_i(route.sfr_sel), .page_we_i(route.page_we),
    .we_i(req_we), .addr_i(req_addr), .wdata_i(req_wdata), .sfr_rdata(sfr_rdata),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_page(sfr_page), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .cap_q(cap_q), .page_rd_q(page_rd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_NONE;
      bitpos_q  <= '0;
    end else begin
      rsp_valid <= req_valid;
      src_q     <= route.src;
      bitpos_q  <= route.bit_pos;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_RAM_BYTE: rsp_data = ram_rdata;
      SRC_RAM_BIT:  rsp_data = {7'b0, ram_rdata[bitpos_q]};
      SRC_SFR:      rsp_data = cap_q;
      SRC_PAGE:     rsp_data = page_rd_q;
      default:      rsp_data = '0;
    endcase
  end

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  sfr_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_sel |-> !route.ram_we);
endmodule

// File: tb/sim_idata_unit.sv
`timescale 1ns/1ps
module sim_idata_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_indirect = 1'b0, req_we = 1'b0, req_bit = 1'b0;
  logic [1:0] req_kind = 2'b00, bank_sel = 2'b00;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, sfr_sel, sfr_we;
  logic [7:0] rsp_data, sfr_page, sfr_addr, sfr_wdata, sfr_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_ram [256];
  logic [7:0] ref_page = 8'h00;

  always #2.5 clk = ~clk;

  assign sfr_rdata = sfr_sel ? (sfr_page ^ {sfr_addr[6:0], 1'b1}) : 8'h00;

  idata_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_indirect(req_indirect), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .bank_sel(bank_sel), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sfr_sel(sfr_sel), .sfr_we(sfr_we), .sfr_page(sfr_page),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic ind, input logic we, input logic [7:0] a,
                    input logic [7:0] wd, input logic bv, input logic [1:0] bk, input string tag);
    logic exp_sel;
    logic [7:0] exp_d, ra;
    exp_sel = 1'b0;
    exp_d = 8'h00;
    if (k == 2'b01) begin
      ra = {3'b000, bk, a[2:0]};
      exp_d = ref_ram[ra];
      if (we) ref_ram[ra] = wd;
    end else if (k == 2'b10) begin
      if (!a[7]) begin
        ra = 8'h20 + {4'b0, a[6:3]};
        exp_d = {7'b0, ref_ram[ra][a[2:0]]};
        if (we) ref_ram[ra][a[2:0]] = bv;
      end
    end else if (a[7] && !ind) begin
      if (a == 8'h84) begin
        exp_d = ref_page;
        if (we) ref_page = wd;
      end else begin
        exp_sel = 1'b1;
        exp_d = ref_page ^ {a[6:0], 1'b1};
      end
    end else begin
      exp_d = ref_ram[a];
      if (we) ref_ram[a] = wd;
    end
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_indirect = ind; req_we = we;
    req_addr = a; req_wdata = wd; req_bit = bv; bank_sel = bk;
    #1;
    chk(sfr_sel == exp_sel, {tag, " sfr_sel"}, {7'b0, sfr_sel}, {7'b0, exp_sel});
    if (exp_sel) begin
      chk(sfr_page == exp_d ^ {a[6:0], 1'b1}, {tag, " sfr_page"}, sfr_page, exp_d ^ {a[6:0], 1'b1});
      chk(sfr_addr == a && sfr_we == we && (!we || sfr_wdata == wd), {tag, " sfr fields"}, sfr_addr, a);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, {7'b0, rsp_valid}, 8'h01);
    chk(rsp_data == exp_d, {tag, " rsp_data"}, rsp_data, exp_d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 rsp_valid idle", {7'b0, rsp_valid}, 8'h00);
    chk(sfr_sel == 1'b0, "R10 sfr_sel idle", {7'b0, sfr_sel}, 8'h00);
    chk(req_ready == 1'b1, "R9 ready", {7'b0, req_ready}, 8'h01);
    op(2'b00, 1'b0, 1'b0, 8'h84, 8'h00, 1'b0, 2'b00, "R7 page reset");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 256; i++)
      op(2'b00, 1'b1, 1'b1, 8'(i), 8'(i * 37 + 11), 1'b0, 2'b00, "R1 fill");
    for (int i = 0; i < 256; i += 7)
      op(2'b00, 1'b1, 1'b0, 8'(i), 8'h00, 1'b0, 2'b00, "R1 readback");
    op(2'b00, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 2'b00, "R1 top byte");
  endtask

  task automatic t_low_alias();
    op(2'b00, 1'b0, 1'b1, 8'h45, 8'hC7, 1'b0, 2'b00, "R2 direct write");
    op(2'b00, 1'b1, 1'b0, 8'h45, 8'h00, 1'b0, 2'b00, "R2 indirect read");
    op(2'b11, 1'b1, 1'b1, 8'h7F, 8'h3E, 1'b0, 2'b00, "R2 kind11 write");
    op(2'b00, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0, 2'b00, "R2 direct read");
  endtask

  task automatic t_upper();
    op(2'b00, 1'b1, 1'b1, 8'h90, 8'hA5, 1'b0, 2'b00, "R3 indirect write");
    op(2'b00, 1'b0, 1'b1, 8'h90, 8'h11, 1'b0, 2'b00, "R8 direct sfr write");
    op(2'b00, 1'b0, 1'b0, 8'hC3, 8'h00, 1'b0, 2'b00, "R8 direct sfr read");
    op(2'b00, 1'b1, 1'b0, 8'h90, 8'h00, 1'b0, 2'b00, "R3 ram untouched");
    op(2'b00, 1'b0, 1'b1, 8'hFF, 8'h22, 1'b0, 2'b00, "R8 sfr top");
    op(2'b00, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 2'b00, "R3 ram top untouched");
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++)
      op(2'b01, b[0], 1'b1, 8'h05, 8'(8'h60 + b), 1'b0, 2'(b), "R4 reg write");
    for (int b = 0; b < 4; b++)
      op(2'b00, 1'b1, 1'b0, 8'(b * 8 + 5), 8'h00, 1'b0, 2'b00, "R4 byte view");
    op(2'b01, 1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 2'b10, "R4 reg7 bank2");
  endtask

  task automatic t_bits();
    op(2'b00, 1'b1, 1'b1, 8'h2C, 8'h00, 1'b0, 2'b00, "R5 clear byte");
    op(2'b10, 1'b0, 1'b1, 8'h61, 8'h00, 1'b1, 2'b00, "R5 bit set");
    op(2'b00, 1'b1, 1'b0, 8'h2C, 8'h00, 1'b0, 2'b00, "R5 byte after set");
    op(2'b10, 1'b0, 1'b0, 8'h61, 8'h00, 1'b0, 2'b00, "R5 bit read one");
    op(2'b00, 1'b1, 1'b1, 8'h2F, 8'hFF, 1'b0, 2'b00, "R5 fill 2F");
    op(2'b10, 1'b0, 1'b1, 8'h7F, 8'h00, 1'b0, 2'b00, "R5 bit clear");
    op(2'b00, 1'b1, 1'b0, 8'h2F, 8'h00, 1'b0, 2'b00, "R5 byte after clear");
    op(2'b10, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0, 2'b00, "R5 bit zero");
  endtask

  task automatic t_bit_high();
    op(2'b00, 1'b1, 1'b1, 8'h30, 8'h00, 1'b0, 2'b00, "R6 preset 30");
    op(2'b00, 1'b1, 1'b1, 8'h20, 8'h00, 1'b0, 2'b00, "R6 preset 20");
    op(2'b10, 1'b0, 1'b1, 8'h80, 8'h00, 1'b1, 2'b00, "R6 high bit write");
    op(2'b10, 1'b0, 1'b1, 8'hF8, 8'h00, 1'b1, 2'b00, "R6 high bit write2");
    op(2'b00, 1'b1, 1'b0, 8'h30, 8'h00, 1'b0, 2'b00, "R6 30 unchanged");
    op(2'b00, 1'b1, 1'b0, 8'h20, 8'h00, 1'b0, 2'b00, "R6 20 unchanged");
    op(2'b10, 1'b0, 1'b0, 8'h80, 8'h00, 1'b0, 2'b00, "R6 high bit read");
  endtask

  task automatic t_page();
    op(2'b00, 1'b0, 1'b1, 8'h84, 8'h3C, 1'b0, 2'b00, "R7 page write");
    op(2'b00, 1'b0, 1'b0, 8'hA0, 8'h00, 1'b0, 2'b00, "R8 page on strobe");
    op(2'b00, 1'b0, 1'b0, 8'h84, 8'h00, 1'b0, 2'b00, "R7 page read");
    op(2'b00, 1'b1, 1'b0, 8'h84, 8'h00, 1'b0, 2'b00, "R7 indirect 84 is ram");
    op(2'b00, 1'b0, 1'b1, 8'h84, 8'hF1, 1'b0, 2'b00, "R7 page write2");
    op(2'b00, 1'b0, 1'b1, 8'hB7, 8'h9D, 1'b0, 2'b00, "R8 new page strobe");
  endtask

  task automatic t_rdw();
    op(2'b00, 1'b1, 1'b1, 8'h50, 8'h12, 1'b0, 2'b00, "R9 write returns old");
    op(2'b00, 1'b1, 1'b1, 8'h50, 8'h34, 1'b0, 2'b00, "R9 write returns prior");
    op(2'b00, 1'b1, 1'b0, 8'h50, 8'h00, 1'b0, 2'b00, "R9 final");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 single pulse", {7'b0, rsp_valid}, 8'h00);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_low_alias();
    t_upper();
    t_banks();
    t_bits();
    t_bit_high();
    t_page();
    t_rdw();
    summary();
  end
endmodule